// File: doc/BRIEF.md
# Multi-Port Storage Adapter Register File

This block is the register file of a storage host adapter that serves several device ports. A host reaches it over a simple 32-bit read/write bus. The low part of the address space holds a few global registers. Above a configurable base, every port has its own 128-byte window. Each port keeps the following state:
- an interrupt cause register, which event inputs from the port datapath set;
- an interrupt enable mask;
- a command register with two derived "running" indications;
- link-control, error and active registers;
- read-only task-file, signature and link-state views.

The global side computes a per-port pending summary and gates it with a global interrupt-enable bit to produce one interrupt line. Writing the adapter reset bit returns every register to its reset value.

Global offsets are as follows:
- 0x00: control. Bit 0 is adapter reset, bit 1 is interrupt enable, and bit 31 is the adapter mode bit, which always reads as one.
- 0x04: pending summary.
- 0x08: implemented-port map.

Port window offsets are as follows:
- 0x00: cause.
- 0x04: mask.
- 0x08: command. Bit 0 is start, bit 1 is spin-up, bit 2 is power-on, bit 4 is receive-enable, bit 14 is receive-running and bit 15 is list-running.
- 0x10: task-file.
- 0x14: signature.
- 0x18: link state.
- 0x1C: link control.
- 0x20: error.
- 0x24: active.

Top module: `hba_regfile`

## Requirements
- R1: A write whose address has bit 1 or bit 0 set changes no register.
- R2: Addresses at or above PORT_BASE select port (addr - PORT_BASE) >> 7, with the register chosen by address bits 6:2. A port index at or beyond NUM_PORTS, and any unlisted offset, reads zero and ignores writes. A write to one port leaves the other ports unchanged.
- R3: A cause bit is set by a one on that port's event input and cleared by writing a one to it. When an event and a clearing write hit the same bit in the same cycle, the bit ends set.
- R4: Only the mask bits in 0xFDC000FF are stored. All other mask bits read zero.
- R5: Summary bit i reads one exactly when port i has a bit set in both its cause and its mask registers. Writing the summary register cannot clear a bit whose cause is still present.
- R6: irq_o is high exactly when the summary is nonzero and control bit 1 is set.
- R7: A control write with bit 0 set resets the adapter. Any other control write stores bit 1. Bit 0 reads as zero, and bit 31 always reads as one.
- R8: In the command register, bit 15 always equals bit 0 and bit 14 always equals bit 4. Values written to bits 14 and 15 are discarded.
- R9: Error bits are set by the error event input and cleared by writing ones to them. Writing the active register ORs the written value into it, and its bits fall only on reset.
- R10: Task-file, signature and link-state ignore writes. Link state reads the port's link input in its low LINK_W bits.
- R11: After reset, the following values hold:
  - command reads 0x6;
  - task-file reads 0x7F;
  - signature reads 0xFFFFFFFF;
  - control reads 0x80000000;
  - every cause, mask, link-control, error and active register reads zero.
- R12: The implemented-port map reads (1 << NUM_PORTS) - 1.
- R13: Read data appears on bus_rdata on the clock edge that follows the read request, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| port_irq_evt | input | NUM_PORTS*32 | Per-port cause-set pulses, port i at bits [32i+31:32i] |
| port_err_evt | input | NUM_PORTS*32 | Per-port error-set pulses |
| port_link_stat | input | NUM_PORTS*LINK_W | Per-port link state shown read-only |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
The bench targets several corner cases, each with the failure it would expose:
- An event and a clearing write that land in the same cycle. A design that lets the clear win drops the interrupt.
- A summary clear while the cause is still pending. A design that latches the summary would lose the interrupt line.
- Misaligned writes. A design that ignores the low address bits would overwrite the control register or the cause register.
- Writes to the running bits of the command register. A design that stores them directly would desynchronise them from the start and receive-enable bits.
- An access just past the last port window. A wrong decode would alias it onto a real port.
- The adapter reset through the control register. It must restore every port, including its mask and active bits.

// File: rtl/hba_reg_pkg.sv
package hba_reg_pkg;

  localparam int DW        = 32;
  localparam int WIN_SHIFT = 7;

  // port window offsets
  localparam logic [6:0] P_CAUSE = 7'h00;
  localparam logic [6:0] P_MASK  = 7'h04;
  localparam logic [6:0] P_CMD   = 7'h08;
  localparam logic [6:0] P_TFD   = 7'h10;
  localparam logic [6:0] P_SIG   = 7'h14;
  localparam logic [6:0] P_LINK  = 7'h18;
  localparam logic [6:0] P_LCTL  = 7'h1C;
  localparam logic [6:0] P_ERR   = 7'h20;
  localparam logic [6:0] P_ACT   = 7'h24;

  // global offsets
  localparam int G_CTRL = 'h00;
  localparam int G_SUM  = 'h04;
  localparam int G_IMPL = 'h08;

  // bit positions
  localparam int CMD_START = 0;
  localparam int CMD_RXEN  = 4;
  localparam int CMD_RXRUN = 14;
  localparam int CMD_LRUN  = 15;
  localparam int CTL_SRST  = 0;
  localparam int CTL_IE    = 1;
  localparam int CTL_MODE  = 31;

  localparam logic [DW-1:0] MASK_WR  = 32'hFDC0_00FF;
  localparam logic [DW-1:0] CMD_RST  = 32'h0000_0006;
  localparam logic [DW-1:0] TFD_RST  = 32'h0000_007F;
  localparam logic [DW-1:0] SIG_RST  = 32'hFFFF_FFFF;
  localparam logic [DW-1:0] CTRL_RST = 32'h8000_0000;

  // clear-by-one with set priority
  function automatic logic [DW-1:0] clr_set(input logic [DW-1:0] cur,
                                            input logic [DW-1:0] clr,
                                            input logic [DW-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  // command write: running bits mirror their controls
  function automatic logic [DW-1:0] cmd_fold(input logic [DW-1:0] wv);
    logic [DW-1:0] v;
    v = wv;
    v[CMD_RXRUN] = wv[CMD_RXEN];
    v[CMD_LRUN]  = wv[CMD_START];
    return v;
  endfunction

  // control write without reset: keep enable, force mode bit
  function automatic logic [DW-1:0] ctrl_fold(input logic ie);
    logic [DW-1:0] v;
    v = CTRL_RST;
    v[CTL_IE] = ie;
    return v;
  endfunction

  function automatic logic [DW-1:0] impl_map(input int n);
    logic [DW-1:0] v;
    v = '0;
    for (int i = 0; i < n; i++) v[i] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/hba_addr_dec.sv
module hba_addr_dec
  import hba_reg_pkg::*;
#(
  parameter int              NUM_PORTS = 4,
  parameter int              ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] PORT_BASE = 'h100
) (
  input  logic                 sel,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 glob_hit,
  output logic                 glob_wr_ctrl,
  output logic [ADDR_W-1:0]    glob_off,
  output logic [NUM_PORTS-1:0] port_sel,
  output logic [NUM_PORTS-1:0] port_wr,
  output logic [6:0]           port_off
);
  localparam logic [ADDR_W:0] PORT_END =
    (ADDR_W+1)'(int'(PORT_BASE) + NUM_PORTS * (1 << WIN_SHIFT));

  logic              aligned, wr_ok, port_hit;
  logic [ADDR_W-1:0] rel, idx;

  assign aligned  = (addr[1:0] == 2'b00);
  assign wr_ok    = sel && we && aligned;
  assign glob_hit = (addr < PORT_BASE);
  assign port_hit = (addr >= PORT_BASE) && ({1'b0, addr} < PORT_END);
  assign rel      = addr - PORT_BASE;
  assign idx      = rel >> WIN_SHIFT;
  assign port_off = {addr[6:2], 2'b00};
  assign glob_off = {addr[ADDR_W-1:2], 2'b00};
  assign glob_wr_ctrl = wr_ok && glob_hit && (glob_off == ADDR_W'(G_CTRL));

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_sel
    assign port_sel[i] = port_hit && (idx == ADDR_W'(i));
    assign port_wr[i]  = wr_ok && port_sel[i];
  end
endmodule

// File: rtl/hba_port_regs.sv
module hba_port_regs
  import hba_reg_pkg::*;
#(
  parameter int LINK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              wr_en,
  input  logic [6:0]        off,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     cause_evt,
  input  logic [DW-1:0]     err_evt,
  input  logic [LINK_W-1:0] link_stat,
  output logic [DW-1:0]     rdata,
  output logic              pend
);
  logic [DW-1:0] cause_q, mask_q, cmd_q, lctl_q, err_q, act_q, tfd_q, sig_q;
  logic wr_cause, wr_mask, wr_cmd, wr_lctl, wr_err, wr_act;

  assign wr_cause = wr_en && (off == P_CAUSE);
  assign wr_mask  = wr_en && (off == P_MASK);
  assign wr_cmd   = wr_en && (off == P_CMD);
  assign wr_lctl  = wr_en && (off == P_LCTL);
  assign wr_err   = wr_en && (off == P_ERR);
  assign wr_act   = wr_en && (off == P_ACT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0; mask_q <= '0; cmd_q <= CMD_RST; lctl_q <= '0;
      err_q <= '0; act_q <= '0; tfd_q <= TFD_RST; sig_q <= SIG_RST;
    end else if (srst) begin
      cause_q <= '0; mask_q <= '0; cmd_q <= CMD_RST; lctl_q <= '0;
      err_q <= '0; act_q <= '0; tfd_q <= TFD_RST; sig_q <= SIG_RST;
    end else begin
      cause_q <= clr_set(cause_q, wr_cause ? wdata : '0, cause_evt);
      err_q   <= clr_set(err_q, wr_err ? wdata : '0, err_evt);
      if (wr_mask) mask_q <= wdata & MASK_WR;
      if (wr_cmd)  cmd_q  <= cmd_fold(wdata);
      if (wr_lctl) lctl_q <= wdata;
      if (wr_act)  act_q  <= act_q | wdata;
    end
  end

  always_comb begin
    unique case (off)
      P_CAUSE: rdata = cause_q;
      P_MASK:  rdata = mask_q;
      P_CMD:   rdata = cmd_q;
      P_TFD:   rdata = tfd_q;
      P_SIG:   rdata = sig_q;
      P_LINK:  rdata = DW'(link_stat);
      P_LCTL:  rdata = lctl_q;
      P_ERR:   rdata = err_q;
      P_ACT:   rdata = act_q;
      default: rdata = '0;
    endcase
  end

  assign pend = |(cause_q & mask_q);

  p_clear_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cause && !srst && cause_evt == '0) |=> ((cause_q & $past(wdata)) == '0));

  p_event_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && cause_evt != '0) |=> ((cause_q & $past(cause_evt)) == $past(cause_evt)));

  p_mask_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & ~MASK_WR) == '0);

  p_run_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[CMD_LRUN] == cmd_q[CMD_START]) && (cmd_q[CMD_RXRUN] == cmd_q[CMD_RXEN]));

  p_act_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !srst |=> ((act_q & $past(act_q)) == $past(act_q)));

  p_reset_vals_r11: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (cmd_q == CMD_RST && cause_q == '0 && mask_q == '0 && act_q == '0));
endmodule

// File: rtl/hba_glob_regs.sv
module hba_glob_regs
  import hba_reg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ctrl,
  input  logic [1:0]           wbits,
  input  logic [ADDR_W-1:0]    off,
  input  logic [NUM_PORTS-1:0] pend,
  output logic [DW-1:0]        rdata,
  output logic                 srst,
  output logic                 irq_o
);
  localparam logic [DW-1:0] IMPL = impl_map(NUM_PORTS);

  logic [DW-1:0] ctrl_q, summary;

  assign srst    = wr_ctrl && wbits[CTL_SRST];
  assign summary = DW'(pend);
  assign irq_o   = (summary != '0) && ctrl_q[CTL_IE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (srst)    ctrl_q <= CTRL_RST;
    else if (wr_ctrl) ctrl_q <= ctrl_fold(wbits[CTL_IE]);
  end

  always_comb begin
    if (off == ADDR_W'(G_CTRL))      rdata = ctrl_q;
    else if (off == ADDR_W'(G_SUM))  rdata = summary;
    else if (off == ADDR_W'(G_IMPL)) rdata = IMPL;
    else                             rdata = '0;
  end

  p_mode_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CTL_MODE] && !ctrl_q[CTL_SRST]);

  p_srst_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (ctrl_q == CTRL_RST && !irq_o));
endmodule

// File: rtl/hba_regfile.sv
module hba_regfile
  import hba_reg_pkg::*;
#(
  parameter int                NUM_PORTS = 4,
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] PORT_BASE = 'h100,
  parameter int                LINK_W    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic [NUM_PORTS*32-1:0]       port_irq_evt,
  input  logic [NUM_PORTS*32-1:0]       port_err_evt,
  input  logic [NUM_PORTS*LINK_W-1:0]   port_link_stat,
  output logic                          irq_o
);
  logic                 glob_hit, glob_wr_ctrl, srst;
  logic [ADDR_W-1:0]    glob_off;
  logic [NUM_PORTS-1:0] port_sel, port_wr, pend;
  logic [6:0]           port_off;
  logic [DW-1:0]        glob_rd, rd_next;
  logic [DW-1:0]        port_rd [NUM_PORTS];

  hba_addr_dec #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE)) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .glob_hit(glob_hit), .glob_wr_ctrl(glob_wr_ctrl), .glob_off(glob_off),
    .port_sel(port_sel), .port_wr(port_wr), .port_off(port_off));

  hba_glob_regs #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_glob (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(glob_wr_ctrl), .wbits(bus_wdata[1:0]),
    .off(glob_off), .pend(pend), .rdata(glob_rd), .srst(srst), .irq_o(irq_o));

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    hba_port_regs #(.LINK_W(LINK_W)) u_port (
      .clk(clk), .rst_n(rst_n), .srst(srst), .wr_en(port_wr[i]),
      .off(port_off), .wdata(bus_wdata),
      .cause_evt(port_irq_evt[i*32 +: 32]),
      .err_evt(port_err_evt[i*32 +: 32]),
      .link_stat(port_link_stat[i*LINK_W +: LINK_W]),
      .rdata(port_rd[i]), .pend(pend[i]));
  end

  always_comb begin
    rd_next = '0;
    if (glob_hit) rd_next = glob_rd;
    for (int i = 0; i < NUM_PORTS; i++)
      if (port_sel[i]) rd_next = port_rd[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  bus_rdata <= '0;
    else if (bus_sel && !bus_we) bus_rdata <= rd_next;
  end

  p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> $stable(bus_rdata));

  p_misalign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr[1:0] != 2'b00 &&
     port_irq_evt == '0 && port_err_evt == '0) |=> $stable(irq_o));
endmodule

// File: tb/sim_hba_regfile.sv
`timescale 1ns/1ps
module sim_hba_regfile;
  localparam int NP = 4;
  localparam int AW = 12;
  localparam int LW = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NP*32-1:0]  port_irq_evt = '0, port_err_evt = '0;
  logic [NP*LW-1:0]  port_link_stat = '0;
  logic              irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic rd_pend = 1'b0;
  logic [31:0] qexp[$];
  string       qtag[$];

  always #4 clk = ~clk;

  hba_regfile #(.NUM_PORTS(NP), .ADDR_W(AW), .PORT_BASE(12'h100), .LINK_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .port_irq_evt(port_irq_evt), .port_err_evt(port_err_evt),
    .port_link_stat(port_link_stat), .irq_o(irq_o));

  function automatic logic [AW-1:0] pa(input int p, input int off);
    return AW'(32'h100 + p * 128 + off);
  endfunction

  // bench restatement of summary gating: any pending port and enable set
  function automatic logic exp_irq(input logic [NP-1:0] sum, input logic ie);
    return (sum != '0) & ie;
  endfunction

  // monitor side of the scoreboard
  always @(posedge clk) rd_pend <= bus_sel && !bus_we;

  always @(negedge clk) begin
    if (rd_pend) begin
      n_chk++;
      if (qexp.size() == 0) begin
        n_fail++;
        $display("FAIL R13: read data with no expected item, actual %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = qexp.pop_front();
        t = qtag.pop_front();
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    qexp.push_back(e); qtag.push_back(t);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq_o !== e) begin
      n_fail++;
      $display("FAIL %s: irq actual %b expected %b", t, irq_o, e);
    end
  endtask

  task automatic cause_pulse(input int p, input logic [31:0] b);
    port_irq_evt[p*32 +: 32] = b;
    @(negedge clk);
    port_irq_evt = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 / R12 reset state
    rd(AW'('h000), 32'h8000_0000, "R11 ctrl reset");
    rd(AW'('h008), 32'h0000_000F, "R12 implemented map");
    rd(pa(0, 'h08), 32'h0000_0006, "R11 cmd reset");
    rd(pa(0, 'h10), 32'h0000_007F, "R11 task-file reset");
    rd(pa(0, 'h14), 32'hFFFF_FFFF, "R11 signature reset");
    rd(pa(0, 'h00), 32'h0, "R11 cause reset");
    rd(pa(0, 'h04), 32'h0, "R11 mask reset");
    rd(AW'('h004), 32'h0, "R11 summary reset");
    chk_irq(1'b0, "R6 idle after reset");

    // R4 writable mask subset
    wr(pa(1, 'h04), 32'hFFFF_FFFF);
    rd(pa(1, 'h04), 32'hFDC0_00FF, "R4 mask subset");

    // R3 / R5 / R6 events, summary, gating
    cause_pulse(1, 32'h0000_0101);
    rd(pa(1, 'h00), 32'h0000_0101, "R3 event sets cause");
    rd(AW'('h004), 32'h0000_0002, "R5 summary port1");
    chk_irq(exp_irq(4'b0010, 1'b0), "R6 gated by enable");
    wr(AW'('h000), 32'h0000_0002);
    rd(AW'('h000), 32'h8000_0002, "R7 stores enable");
    chk_irq(exp_irq(4'b0010, 1'b1), "R6 asserted");
    wr(AW'('h004), 32'h0000_000F);
    rd(AW'('h004), 32'h0000_0002, "R5 summary not clearable");
    chk_irq(1'b1, "R5 irq stays");
    wr(pa(1, 'h00), 32'h0000_0001);
    rd(pa(1, 'h00), 32'h0000_0100, "R3 write one clears");
    rd(AW'('h004), 32'h0, "R5 unmasked bit ignored");
    chk_irq(1'b0, "R6 deasserted");

    // R3 event and clear in same cycle
    port_irq_evt[32 +: 32] = 32'h1;
    wr(pa(1, 'h00), 32'h0000_0001);
    port_irq_evt = '0;
    rd(pa(1, 'h00), 32'h0000_0101, "R3 event beats clear");
    chk_irq(1'b1, "R3 irq after collision");

    // R1 misaligned writes
    wr(AW'('h001), 32'h0);
    rd(AW'('h000), 32'h8000_0002, "R1 misaligned ctrl write");
    wr(pa(1, 'h02), 32'hFFFF_FFFF);
    rd(pa(1, 'h00), 32'h0000_0101, "R1 misaligned cause write");
    chk_irq(1'b1, "R1 irq unchanged");

    // R8 command running bits
    wr(pa(2, 'h08), 32'h0000_C011);
    rd(pa(2, 'h08), 32'h0000_C011, "R8 start and rx-enable");
    wr(pa(2, 'h08), 32'h0000_C000);
    rd(pa(2, 'h08), 32'h0000_0000, "R8 running bits not writable");
    wr(pa(2, 'h08), 32'h0000_0010);
    rd(pa(2, 'h08), 32'h0000_4010, "R8 rx-running only");

    // R10 read-only views
    port_link_stat[3:0] = 4'h3;
    wr(pa(0, 'h10), 32'h0);
    rd(pa(0, 'h10), 32'h0000_007F, "R10 task-file read-only");
    wr(pa(0, 'h14), 32'h0);
    rd(pa(0, 'h14), 32'hFFFF_FFFF, "R10 signature read-only");
    wr(pa(0, 'h18), 32'h0);
    rd(pa(0, 'h18), 32'h0000_0003, "R10 link state");
    wr(pa(0, 'h1C), 32'h0000_005A);
    rd(pa(0, 'h1C), 32'h0000_005A, "R10 link control stores");

    // R9 error and active
    port_err_evt[96 +: 32] = 32'hF0;
    @(negedge clk);
    port_err_evt = '0;
    rd(pa(3, 'h20), 32'h0000_00F0, "R9 error set");
    wr(pa(3, 'h20), 32'h0000_0030);
    rd(pa(3, 'h20), 32'h0000_00C0, "R9 error clear");
    wr(pa(3, 'h24), 32'h5);
    wr(pa(3, 'h24), 32'h8);
    rd(pa(3, 'h24), 32'h0000_000D, "R9 active ors");

    // R2 decode
    wr(pa(3, 'h04), 32'h1);
    rd(pa(3, 'h04), 32'h1, "R2 port3 mask");
    rd(pa(2, 'h04), 32'h0, "R2 neighbour untouched");
    wr(AW'('h300), 32'hFFFF_FFFF);
    rd(AW'('h300), 32'h0, "R2 beyond last port");
    rd(pa(0, 'h7C), 32'h0, "R2 unlisted port offset");
    rd(AW'('h040), 32'h0, "R2 unlisted global offset");

    // R7 / R11 adapter reset
    wr(AW'('h000), 32'h0000_0003);
    rd(AW'('h000), 32'h8000_0000, "R7 reset clears ctrl");
    rd(pa(1, 'h00), 32'h0, "R11 cause after reset");
    rd(pa(1, 'h04), 32'h0, "R11 mask after reset");
    rd(pa(2, 'h08), 32'h0000_0006, "R11 cmd after reset");
    rd(pa(3, 'h20), 32'h0, "R11 error after reset");
    rd(pa(3, 'h24), 32'h0, "R11 active after reset");
    rd(pa(0, 'h1C), 32'h0, "R11 link control after reset");
    chk_irq(1'b0, "R7 irq low after reset");

    // R13 hold between reads
    rd(pa(0, 'h14), 32'hFFFF_FFFF, "R13 read");
    repeat (3) @(negedge clk);
    n_chk++;
    if (bus_rdata !== 32'hFFFF_FFFF) begin
      n_fail++;
      $display("FAIL R13 hold: actual %h expected %h", bus_rdata, 32'hFFFF_FFFF);
    end
    n_chk++;
    if (qexp.size() != 0) begin
      n_fail++;
      $display("FAIL R13 scoreboard: actual %0d left expected 0", qexp.size());
    end
    finish_run();
  end
endmodule